// File: doc/BRIEF.md
# Receive Frame Length Screening and Statistics

This block sits after the receive frame parser. Once per frame it gets a single-cycle strobe. The strobe carries the frame length with the CRC already removed, a traffic class (unicast, multicast or broadcast) and two control bits. The first control bit raises the length ceiling for jumbo frames. The second tells the block to keep frames that would otherwise be rejected.

The block decides whether the frame is too long. A frame that is too long, and not covered by the keep control, is rejected with a one-cycle drop pulse. In that case only the oversize tally advances. A frame that is kept advances these statistics:

- the packet tallies
- the class tallies
- a six-bin size histogram, binned on the length including the CRC
- two wide octet accumulators

Every statistic saturates instead of wrapping. All of them can be read at any time through a 32-bit combinational read port. The wide accumulators are split into low and high words. Reading a statistic does not disturb it, and only reset clears it.

Top module: `rx_len_stats`

## Requirements
- R1: When `long_en` is 0, a frame with `frm_len` greater than SHORT_MAX (default 1518, which is a 14-byte header, a 4-byte tag and 1500 payload bytes) is oversized. A length of exactly SHORT_MAX is not oversized.
- R2: When `long_en` is 1, a frame with `frm_len` greater than LONG_MAX (default 16380, which is 16384 minus the 4 CRC bytes) is oversized. A length of exactly LONG_MAX is not oversized.
- R3: When `keep_bad` is 1, no frame is oversized. Such a frame raises no drop and does not advance the oversize tally. It is counted as a kept frame.
- R4: An oversized frame produces `drop` high for exactly the one cycle after its strobe, and advances the oversize tally (address 0). It changes no other statistic.
- R5: Each kept frame advances both the total-frame tally (address 1) and the good-frame tally (address 2) by one.
- R6: `frm_class` encoding: 0 = unicast, 1 = multicast, 2 = broadcast, 3 = treated as unicast. A kept broadcast frame advances address 3. A kept multicast frame advances address 4. A unicast frame advances neither.
- R7: A kept frame falls into at most one size bin, chosen by `frm_len`+4:
  - exactly 64 goes to address 5
  - 65–127 goes to address 6
  - 128–255 goes to address 7
  - 256–511 goes to address 8
  - 512–1023 goes to address 9
  - 1024 and above goes to address 10

  A frame below 64 lands in no bin.
- R8: Each kept frame adds `frm_len`+4 to both octet accumulators. The total accumulator is at addresses 11 (bits 31:0) and 12 (bits 63:32, zero above OCT_W). The good accumulator is at addresses 13 and 14. Each accumulator saturates at all ones of OCT_W bits.
- R9: Every tally holds at its maximum (2^CNT_W−1) instead of wrapping, and never decreases except at reset.
- R10: After reset every address reads 0. A read returns the current value on the same cycle and does not change it. Address 15 always reads 0. A statistic updated by a strobe shows its new value from the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | One-cycle frame strobe |
| frm_len | input | LEN_W | Frame length in bytes, CRC excluded |
| frm_class | input | 2 | Traffic class of the frame |
| long_en | input | 1 | Selects the jumbo length ceiling |
| keep_bad | input | 1 | Suppresses oversize rejection |
| drop | output | 1 | Oversize reject pulse, one cycle after the strobe |
| rd_addr | input | 4 | Statistic select |
| rd_data | output | 32 | Selected statistic word |

## Verification
The bench builds the block with CNT_W = 4 and OCT_W = 17, keeping LEN_W = 16 and both default length limits. The narrow tally width lets about twenty repeated frames drive the class, packet, bin and oversize tallies into saturation. The 17-bit accumulators saturate after eight maximum-length jumbo frames, so the octet clamp is reached as well. With OCT_W = 17, the high words must read zero. All length boundaries around 1518, 16380 and every bin edge are crossed directly at these settings.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2,
    CLS_RSVD  = 2'd3
  } frm_class_e;

  localparam int unsigned CRC_BYTES  = 4;
  localparam int unsigned NUM_BINS   = 6;
  localparam int unsigned NO_BIN     = NUM_BINS;

  // packet tally slots (also their read addresses)
  localparam int unsigned IDX_OVER   = 0;
  localparam int unsigned IDX_TOTAL  = 1;
  localparam int unsigned IDX_GOOD   = 2;
  localparam int unsigned IDX_BCAST  = 3;
  localparam int unsigned IDX_MCAST  = 4;
  localparam int unsigned IDX_BIN0   = 5;
  localparam int unsigned NUM_TALLY  = IDX_BIN0 + NUM_BINS;

  localparam int unsigned ADDR_W        = 4;
  localparam int unsigned ADDR_OCT_T_LO = NUM_TALLY;
  localparam int unsigned ADDR_OCT_T_HI = NUM_TALLY + 1;
  localparam int unsigned ADDR_OCT_G_LO = NUM_TALLY + 2;
  localparam int unsigned ADDR_OCT_G_HI = NUM_TALLY + 3;

  // length check against the ceiling selected by the jumbo control
  function automatic logic len_exceeds(input int unsigned len,
                                       input logic        jumbo,
                                       input int unsigned short_max,
                                       input int unsigned long_max);
    int unsigned ceiling;
    ceiling = jumbo ? long_max : short_max;
    return len > ceiling;
  endfunction

  // histogram slot from the on-wire length (CRC included)
  function automatic int unsigned bin_of(input int unsigned wire_len);
    if (wire_len < 64)        return NO_BIN;
    else if (wire_len == 64)  return 0;
    else if (wire_len < 128)  return 1;
    else if (wire_len < 256)  return 2;
    else if (wire_len < 512)  return 3;
    else if (wire_len < 1024) return 4;
    else                      return 5;
  endfunction

endpackage

// File: rtl/rxstat_sat_ctr.sv
module rxstat_sat_ctr #(
  parameter int unsigned W      = 32,
  parameter int unsigned STEP_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      value
);
  localparam int unsigned SUM_W = ((W > STEP_W) ? W : STEP_W) + 1;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  function automatic logic [W-1:0] sat_add(input logic [W-1:0] cur,
                                           input logic [STEP_W-1:0] amt);
    logic [SUM_W-1:0] sum;
    sum = SUM_W'(cur) + SUM_W'(amt);
    if (sum > SUM_W'(MAXV)) return MAXV;
    return sum[W-1:0];
  endfunction

  logic [W-1:0] next_value;
  assign next_value = inc_en ? sat_add(value, step) : value;

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= next_value;
  end

  // R9: a full counter stays full
  a_r9_hold_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    (value == MAXV) |=> (value == MAXV));
  // R9: no wrap, never decreases
  a_r9_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (value >= $past(value)));
  // R10: reads and idle cycles leave the value untouched
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_en |=> $stable(value));

endmodule

// File: rtl/rxstat_len_gate.sv
module rxstat_len_gate
  import rxstat_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned SHORT_MAX = 1518,
  parameter int unsigned LONG_MAX  = 16380
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             long_en,
  input  logic             keep_bad,
  output logic             oversize_ev,
  output logic             accept_ev,
  output logic             drop_q
);
  logic too_long;

  assign too_long    = len_exceeds(int'(frm_len), long_en, SHORT_MAX, LONG_MAX);
  assign oversize_ev = frm_valid && too_long && !keep_bad;
  assign accept_ev   = frm_valid && !oversize_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= oversize_ev;
  end

  // R1: short ceiling
  a_r1_short_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !long_en && !keep_bad && (int'(frm_len) > SHORT_MAX)) |=> drop_q);
  a_r1_short_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !long_en && (int'(frm_len) <= SHORT_MAX)) |=> !drop_q);
  // R2: jumbo ceiling
  a_r2_long_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && long_en && !keep_bad && (int'(frm_len) > LONG_MAX)) |=> drop_q);
  a_r2_long_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && long_en && (int'(frm_len) <= LONG_MAX)) |=> !drop_q);
  // R3: keep control suppresses every drop
  a_r3_keep_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && keep_bad) |=> !drop_q);
  // R4: drop is a single-cycle pulse tied to a strobe
  a_r4_drop_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !drop_q);

endmodule

// File: rtl/rxstat_rd_mux.sv
module rxstat_rd_mux
  import rxstat_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned OCT_W = 64
) (
  input  logic [NUM_TALLY*CNT_W-1:0] tally_flat,
  input  logic [OCT_W-1:0]           oct_total,
  input  logic [OCT_W-1:0]           oct_good,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [31:0]                rd_data
);
  logic [31:0] tally_word [NUM_TALLY];

  for (genvar g = 0; g < NUM_TALLY; g++) begin : g_word
    if (CNT_W >= 32) begin : g_trim
      assign tally_word[g] = tally_flat[g*CNT_W +: 32];
    end else begin : g_ext
      assign tally_word[g] = 32'(tally_flat[g*CNT_W +: CNT_W]);
    end
  end

  function automatic logic [31:0] half_of(input logic [OCT_W-1:0] v,
                                          input logic upper);
    logic [63:0] wide;
    wide = 64'(v);
    return upper ? wide[63:32] : wide[31:0];
  endfunction

  always_comb begin
    rd_data = '0;
    if (int'(rd_addr) < NUM_TALLY) rd_data = tally_word[rd_addr];
    else if (int'(rd_addr) == ADDR_OCT_T_LO) rd_data = half_of(oct_total, 1'b0);
    else if (int'(rd_addr) == ADDR_OCT_T_HI) rd_data = half_of(oct_total, 1'b1);
    else if (int'(rd_addr) == ADDR_OCT_G_LO) rd_data = half_of(oct_good, 1'b0);
    else if (int'(rd_addr) == ADDR_OCT_G_HI) rd_data = half_of(oct_good, 1'b1);
  end

endmodule

// File: rtl/rx_len_stats.sv
module rx_len_stats
  import rxstat_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned OCT_W     = 64,
  parameter int unsigned SHORT_MAX = 1518,
  parameter int unsigned LONG_MAX  = 16380
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  input  logic [LEN_W-1:0] frm_len,
  input  logic [1:0]       frm_class,
  input  logic             long_en,
  input  logic             keep_bad,
  output logic             drop,
  input  logic [3:0]       rd_addr,
  output logic [31:0]      rd_data
);
  localparam int unsigned WIRE_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] TALLY_MAX = {CNT_W{1'b1}};

  // named internal events
  logic                   oversize_ev;
  logic                   accept_ev;
  logic [WIRE_W-1:0]      wire_len;
  logic [NUM_BINS-1:0]    bin_hit;
  logic [NUM_TALLY-1:0]   tally_inc;
  logic [NUM_TALLY*CNT_W-1:0] tally_flat;
  logic [CNT_W-1:0]       tally_val [NUM_TALLY];
  logic [OCT_W-1:0]       oct_total;
  logic [OCT_W-1:0]       oct_good;
  frm_class_e             cls;

  assign cls      = frm_class_e'(frm_class);
  assign wire_len = WIRE_W'(frm_len) + WIRE_W'(CRC_BYTES);

  rxstat_len_gate #(
    .LEN_W(LEN_W), .SHORT_MAX(SHORT_MAX), .LONG_MAX(LONG_MAX)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
    .long_en(long_en), .keep_bad(keep_bad),
    .oversize_ev(oversize_ev), .accept_ev(accept_ev), .drop_q(drop)
  );

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    assign bin_hit[b] = accept_ev && (bin_of(int'(wire_len)) == b);
  end

  always_comb begin
    tally_inc             = '0;
    tally_inc[IDX_OVER]   = oversize_ev;
    tally_inc[IDX_TOTAL]  = accept_ev;
    tally_inc[IDX_GOOD]   = accept_ev;
    tally_inc[IDX_BCAST]  = accept_ev && (cls == CLS_BCAST);
    tally_inc[IDX_MCAST]  = accept_ev && (cls == CLS_MULTI);
    tally_inc[IDX_BIN0 +: NUM_BINS] = bin_hit;
  end

  for (genvar t = 0; t < NUM_TALLY; t++) begin : g_tally
    rxstat_sat_ctr #(.W(CNT_W), .STEP_W(1)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc_en(tally_inc[t]), .step(1'b1),
      .value(tally_val[t])
    );
    assign tally_flat[t*CNT_W +: CNT_W] = tally_val[t];
  end

  rxstat_sat_ctr #(.W(OCT_W), .STEP_W(WIRE_W)) u_oct_total (
    .clk(clk), .rst_n(rst_n), .inc_en(accept_ev), .step(wire_len),
    .value(oct_total)
  );

  rxstat_sat_ctr #(.W(OCT_W), .STEP_W(WIRE_W)) u_oct_good (
    .clk(clk), .rst_n(rst_n), .inc_en(accept_ev), .step(wire_len),
    .value(oct_good)
  );

  rxstat_rd_mux #(.CNT_W(CNT_W), .OCT_W(OCT_W)) u_rd (
    .tally_flat(tally_flat), .oct_total(oct_total), .oct_good(oct_good),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // R7: a frame lands in at most one bin
  a_r7_one_bin: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bin_hit));
  // R7: short frames land nowhere
  a_r7_runt_no_bin: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wire_len) < 64) |-> (bin_hit == '0));
  // R4: an oversize drop freezes the packet tallies
  a_r4_drop_freezes_total: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> (tally_val[IDX_TOTAL] == $past(tally_val[IDX_TOTAL])));
  // R4: and advances the oversize tally unless full
  a_r4_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && ($past(tally_val[IDX_OVER]) != TALLY_MAX)) |->
    (tally_val[IDX_OVER] == $past(tally_val[IDX_OVER]) + 1'b1));
  // R6: unicast frames leave the class tallies alone
  a_r6_unicast_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_ev && (cls == CLS_UNI || cls == CLS_RSVD)) |=>
    ($stable(tally_val[IDX_BCAST]) && $stable(tally_val[IDX_MCAST])));
  // R5: the two packet tallies march together until saturation
  a_r5_pair_equal: assert property (@(posedge clk) disable iff (!rst_n)
    tally_val[IDX_TOTAL] == tally_val[IDX_GOOD]);
  // R8: the two octet accumulators march together
  a_r8_oct_equal: assert property (@(posedge clk) disable iff (!rst_n)
    oct_total == oct_good);

endmodule

// File: tb/rx_len_stats_tb.sv
module rx_len_stats_tb_top;
  localparam int LEN_W = 16;
  localparam int CNT_W = 4;
  localparam int OCT_W = 17;
  localparam longint TMAX = (64'd1 << CNT_W) - 1;
  localparam longint OMAX = (64'd1 << OCT_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic [15:0] frm_len = '0;
  logic [1:0]  frm_class = '0;
  logic        long_en = 1'b0;
  logic        keep_bad = 1'b0;
  logic        drop;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rx_len_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
    .frm_class(frm_class), .long_en(long_en), .keep_bad(keep_bad),
    .drop(drop), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  // bench model
  longint m_tally [11];
  longint m_oct;
  bit     exp_q [$];
  string  tag_q [$];
  bit     seen = 0;

  function automatic longint sat(longint v, longint add, longint mx);
    return (v + add > mx) ? mx : v + add;
  endfunction

  function automatic int slot_for(int wl);
    if (wl == 64) return 5;
    if (wl >= 65 && wl <= 127) return 6;
    if (wl >= 128 && wl <= 255) return 7;
    if (wl >= 256 && wl <= 511) return 8;
    if (wl >= 512 && wl <= 1023) return 9;
    if (wl >= 1024) return 10;
    return -1;
  endfunction

  function automatic longint expect_rd(int a);
    if (a <= 10) return m_tally[a];
    if (a == 11 || a == 13) return m_oct & 64'hFFFF_FFFF;
    if (a == 12 || a == 14) return m_oct >> 32;
    return 0;
  endfunction

  function automatic string req_for(int a);
    if (a == 0) return "R4";
    if (a <= 2) return "R5";
    if (a <= 4) return "R6";
    if (a <= 10) return "R7";
    if (a <= 14) return "R8";
    return "R10";
  endfunction

  task automatic report(bit ok, string req, longint act, longint exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(int len, int cls, bit le, bit kb, string req);
    int lim;
    bit over;
    int slot;
    @(negedge clk);
    frm_valid = 1'b1; frm_len = 16'(len); frm_class = 2'(cls);
    long_en = le; keep_bad = kb;
    lim  = le ? 16380 : 1518;
    over = (len > lim) && !kb;
    exp_q.push_back(over);
    tag_q.push_back(req);
    if (over) m_tally[0] = sat(m_tally[0], 1, TMAX);
    else begin
      m_tally[1] = sat(m_tally[1], 1, TMAX);
      m_tally[2] = sat(m_tally[2], 1, TMAX);
      if (cls == 2) m_tally[3] = sat(m_tally[3], 1, TMAX);
      if (cls == 1) m_tally[4] = sat(m_tally[4], 1, TMAX);
      slot = slot_for(len + 4);
      if (slot >= 0) m_tally[slot] = sat(m_tally[slot], 1, TMAX);
      m_oct = sat(m_oct, len + 4, OMAX);
    end
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  // monitor: compare drop one cycle after each strobe
  always @(posedge clk) seen <= frm_valid;

  always @(negedge clk) begin
    if (seen) begin
      if (exp_q.size() == 0) report(1'b0, "R4", drop, 0, "unexpected strobe");
      else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        report(drop == e, t, drop, e, "drop pulse");
      end
    end else if (rst_n) begin
      report(drop == 1'b0, "R4", drop, 0, "drop without strobe");
    end
  end

  task automatic check_rd(int a, string why);
    longint e;
    @(negedge clk);
    rd_addr = 4'(a);
    #1;
    e = expect_rd(a);
    report(longint'(rd_data) == e, req_for(a), rd_data, e, why);
  endtask

  task automatic sweep(string why);
    for (int a = 0; a < 16; a++) check_rd(a, why);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    report(1'b0, "R10", 0, 1, "watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 11; i++) m_tally[i] = 0;
    m_oct = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state, every address zero
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); rd_addr = 4'(a); #1;
      report(rd_data == 32'd0, "R10", rd_data, 0, "reset value");
    end

    send(60, 0, 0, 0, "R7");     // wire 64, unicast
    send(61, 1, 0, 0, "R6");     // wire 65, multicast
    send(59, 2, 0, 0, "R7");     // wire 63, no bin, broadcast
    send(123, 3, 0, 0, "R6");    // wire 127, class 3 as unicast
    send(124, 0, 0, 0, "R7");    // 128
    send(251, 0, 0, 0, "R7");    // 255
    send(252, 1, 0, 0, "R7");    // 256
    send(507, 0, 0, 0, "R7");    // 511
    send(508, 2, 0, 0, "R7");    // 512
    send(1019, 0, 0, 0, "R7");   // 1023
    send(1020, 0, 0, 0, "R7");   // 1024
    send(1518, 0, 0, 0, "R1");   // at short ceiling
    send(1519, 0, 0, 0, "R1");   // just over
    send(1519, 0, 1, 0, "R2");   // jumbo allows it
    send(16380, 0, 1, 0, "R2");  // at jumbo ceiling
    send(16381, 0, 1, 0, "R2");  // just over
    send(2000, 2, 0, 1, "R3");   // kept despite length
    send(20000, 0, 1, 1, "R3");  // kept despite jumbo ceiling
    repeat (2) @(negedge clk);
    sweep("after boundary frames");
    // R10: reading twice does not clear
    sweep("second read R10");

    // R9: saturation of tallies and octets
    for (int i = 0; i < 20; i++) send(60, 2, 0, 0, "R9");
    for (int i = 0; i < 20; i++) send(3000, 1, 0, 0, "R9");
    for (int i = 0; i < 9; i++) send(16380, 0, 1, 0, "R8");
    repeat (2) @(negedge clk);
    sweep("after saturation R9");
    send(100, 1, 0, 0, "R9");
    repeat (2) @(negedge clk);
    sweep("held at max R9");

    finish_run();
  end
endmodule